// File: doc/BRIEF.md
# Six-Stage Pipeline Stall and Bypass Controller

This block decides, each cycle, whether the instruction waiting in the decode stage of a six-stage in-order integer pipeline (fetch, decode, execute-1, execute-2, memory, write-back) may move into execute-1. If it may, the block also decides where each of its two source operands comes from. It keeps its own shadow of the four stages past decode. Each shadow slot holds a destination register and the kind of the instruction there. Simple ALU results are ready after execute-1, multiply results after execute-2, and load data after memory.

The bypass paths are set at run time by a two-bit mode input. Full mode allows bypass from the EX1, EX2 and M results plus a same-cycle register-file write-then-read. Register-file-only mode allows only the write-then-read. M-only mode allows only the memory-stage bypass. When no enabled path can supply an operand in time, the block freezes fetch and decode and places a NOP into execute-1. It repeats this for as many cycles as needed.

The forwarding selects are registered. They are valid during the cycle in which the consumer occupies execute-1.

Top module: `hazard_fwd_unit`

## Requirements
- R1: In full mode (cfg_mode=0), an ALU consumer directly behind an ALU producer does not stall and reads that operand with select 1 (result of EX1). Select codes: 0 register file, 1 result of EX1, 2 result of EX2, 3 result of M.
- R2: In full mode, a consumer directly behind a multiply stalls exactly one cycle and then uses select 2. A consumer behind a multiply that already left EX2 uses select 3.
- R3: In full mode, a consumer directly behind a load stalls exactly two cycles and then uses select 3.
- R4: In register-file-only mode (cfg_mode=1, and also the reserved value 3), a dependent consumer stalls until its producer is in write-back, and every select stays 0.
- R5: In M-only mode (cfg_mode=2), a dependent consumer stalls until its producer is in M and then uses select 3. A producer that has reached write-back still forces a stall, because register-file forwarding is off, and only selects 0 or 3 ever appear.
- R6: Register 0 is never a hazard. A destination of 0 is never matched, and a source of 0 never stalls and always gets select 0.
- R7: When several in-flight instructions write the consumer's register, only the youngest is considered, both for the stall decision and for the select.
- R8: stall_if, stall_id and bubble_ex1 are asserted together. In the cycle after a stall, the bubble in execute-1 carries selects 0. A run of stalls never exceeds four cycles.
- R9: After reset, no stall is signalled and both selects are 0.
- R10: When id_valid is 0, no stall is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Bypass mode: 0 full, 1 register file only, 2 M only, 3 as 1 |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_kind | input | 2 | Kind of decode instruction: 0 ALU, 1 multiply, 2 load |
| id_rd | input | 5 | Destination register of decode instruction (0 = none) |
| id_rs1 | input | 5 | First source register (0 = unused) |
| id_rs2 | input | 5 | Second source register (0 = unused) |
| stall_if | output | 1 | Hold the PC |
| stall_id | output | 1 | Hold the decode register |
| bubble_ex1 | output | 1 | Load a NOP into execute-1 |
| fwd_sel_a | output | 2 | Operand-1 source for the instruction in execute-1 |
| fwd_sel_b | output | 2 | Operand-2 source for the instruction in execute-1 |

## Verification
Short instruction sequences are replayed in every mode. The bench counts stall cycles and the total cycle count, and checks both selects while each instruction sits in execute-1. An ALU, multiply and logic chain and a load, add and load chain tell apart the three producer latencies under each path set. The same program yields a different stall count and select pattern per mode. A sequence that writes register 0, and a pair of sequences where an older and a younger producer share a destination in opposite latency order, separate correct register-0 handling and youngest-first matching from plausible mistakes.

// File: rtl/hzu_pkg.sv
package hzu_pkg;
  localparam int RAW  = 5;  // register address width
  localparam int NSTG = 4;  // tracked stages after decode: EX1, EX2, M, WB

  typedef enum logic [1:0] {K_ALU = 2'd0, K_MUL = 2'd1, K_LOAD = 2'd2, K_RSV = 2'd3} kind_e;
  typedef enum logic [1:0] {M_FULL = 2'd0, M_RF = 2'd1, M_MEM = 2'd2, M_RSV = 2'd3} mode_e;

  typedef struct packed {
    logic           v;
    logic [RAW-1:0] rd;
    kind_e          kind;
  } slot_t;

  // Stage position (1 = EX1 .. 4 = WB) at whose end the result exists.
  function automatic int ready_pos(kind_e k);
    case (k)
      K_ALU:   return 1;
      K_MUL:   return 2;
      default: return 3;
    endcase
  endfunction

  // Can a producer currently at position p feed a consumer leaving decode?
  function automatic logic path_on(mode_e m, int p);
    case (m)
      M_FULL:  return 1'b1;
      M_MEM:   return p == 3;
      default: return p == 4;
    endcase
  endfunction
endpackage

// File: rtl/hzu_track.sv
module hzu_track
  import hzu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  slot_t                ins,
  output slot_t [NSTG-1:0]     stg
);
  slot_t [NSTG-1:0] stg_d, stg_q;

  always_comb begin
    stg_d[0] = ins;
    for (int i = 1; i < NSTG; i++) stg_d[i] = stg_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign stg = stg_q;
endmodule

// File: rtl/hzu_resolve.sv
module hzu_resolve
  import hzu_pkg::*;
(
  input  logic [RAW-1:0]       rs,
  input  slot_t [NSTG-1:0]     stg,
  input  logic [1:0]           mode,
  output logic                 hold,
  output logic [1:0]           sel
);
  always_comb begin
    logic found;
    found = 1'b0;
    hold  = 1'b0;
    sel   = 2'd0;
    for (int i = 0; i < NSTG; i++) begin
      if (!found && rs != '0 && stg[i].v && stg[i].rd == rs) begin
        found = 1'b1;
        if (ready_pos(stg[i].kind) <= i + 1 && path_on(mode_e'(mode), i + 1)) begin
          sel = (i < NSTG - 1) ? 2'(i + 1) : 2'd0;
        end else begin
          hold = 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hzu_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic [1:0]     cfg_mode,
  input  logic           id_valid,
  input  logic [1:0]     id_kind,
  input  logic [RAW-1:0] id_rd,
  input  logic [RAW-1:0] id_rs1,
  input  logic [RAW-1:0] id_rs2,
  output logic           stall_if,
  output logic           stall_id,
  output logic           bubble_ex1,
  output logic [1:0]     fwd_sel_a,
  output logic [1:0]     fwd_sel_b
);
  localparam int NOPS = 2;

  slot_t [NSTG-1:0]   stg;
  slot_t              ins;
  logic [RAW-1:0]     rs_v   [NOPS];
  logic [NOPS-1:0]    hold_v;
  logic [1:0]         sel_v  [NOPS];
  logic [1:0]         sel_d  [NOPS];
  logic [1:0]         sel_q  [NOPS];
  logic               stall;
  logic               adv;

  assign rs_v[0] = id_rs1;
  assign rs_v[1] = id_rs2;

  generate
    for (genvar g = 0; g < NOPS; g++) begin : g_op
      hzu_resolve u_res (
        .rs   (rs_v[g]),
        .stg  (stg),
        .mode (cfg_mode),
        .hold (hold_v[g]),
        .sel  (sel_v[g])
      );
    end
  endgenerate

  assign stall = id_valid && (|hold_v);
  assign adv   = id_valid && !stall;

  always_comb begin
    ins = '0;
    if (adv && id_rd != '0) begin
      ins.v    = 1'b1;
      ins.rd   = id_rd;
      ins.kind = kind_e'(id_kind);
    end
  end

  hzu_track u_trk (
    .clk   (clk),
    .rst_n (rst_n),
    .ins   (ins),
    .stg   (stg)
  );

  always_comb begin
    for (int i = 0; i < NOPS; i++) sel_d[i] = adv ? sel_v[i] : 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NOPS; i++) sel_q[i] <= 2'd0;
    end else begin
      for (int i = 0; i < NOPS; i++) sel_q[i] <= sel_d[i];
    end
  end

  assign stall_if   = stall;
  assign stall_id   = stall;
  assign bubble_ex1 = stall;
  assign fwd_sel_a  = sel_q[0];
  assign fwd_sel_b  = sel_q[1];
endmodule

// File: rtl/hzu_chk.sv
module hzu_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] cfg_mode,
  input logic       id_valid,
  input logic [4:0] id_rs1,
  input logic [4:0] id_rs2,
  input logic       stall_if,
  input logic       stall_id,
  input logic       bubble_ex1,
  input logic [1:0] fwd_sel_a,
  input logic [1:0] fwd_sel_b
);
  localparam int MAX_RUN = 4;
  logic [2:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        run_q <= '0;
    else if (stall_id) run_q <= run_q + 3'd1;
    else               run_q <= '0;
  end

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !id_valid |-> !stall_if);

  p_bubble_nofwd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_id |=> (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

  p_stall_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(run_q) <= MAX_RUN);

  p_ctl_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stall_if |-> (stall_id && bubble_ex1));

  p_rf_nobypass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode[0] && id_valid && !stall_id) |=> (fwd_sel_a == 2'd0 && fwd_sel_b == 2'd0));

  p_mem_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_mode == 2'd2 && id_valid && !stall_id) |=>
      ((fwd_sel_a == 2'd0 || fwd_sel_a == 2'd3) && (fwd_sel_b == 2'd0 || fwd_sel_b == 2'd3)));

  p_x0_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (id_valid && id_rs1 == 5'd0 && id_rs2 == 5'd0) |-> !stall_if);
endmodule

bind hazard_fwd_unit hzu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_mode   (cfg_mode),
  .id_valid   (id_valid),
  .id_rs1     (id_rs1),
  .id_rs2     (id_rs2),
  .stall_if   (stall_if),
  .stall_id   (stall_id),
  .bubble_ex1 (bubble_ex1),
  .fwd_sel_a  (fwd_sel_a),
  .fwd_sel_b  (fwd_sel_b)
);

// File: tb/hazard_fwd_unit_bench.sv
module hazard_fwd_unit_bench;
  logic       clk;
  logic       rst_n;
  logic [1:0] cfg_mode;
  logic       id_valid;
  logic [1:0] id_kind;
  logic [4:0] id_rd, id_rs1, id_rs2;
  logic       stall_if, stall_id, bubble_ex1;
  logic [1:0] fwd_sel_a, fwd_sel_b;

  int n_chk = 0;
  int n_err = 0;

  logic [1:0] p_kind [8];
  logic [4:0] p_rd   [8];
  logic [4:0] p_rs1  [8];
  logic [4:0] p_rs2  [8];
  logic [1:0] e_a    [8];
  logic [1:0] e_b    [8];

  localparam logic [1:0] ALU = 2'd0, MUL = 2'd1, LD = 2'd2;

  hazard_fwd_unit u_hazard_fwd_unit (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .id_valid(id_valid),
    .id_kind(id_kind), .id_rd(id_rd), .id_rs1(id_rs1), .id_rs2(id_rs2),
    .stall_if(stall_if), .stall_id(stall_id), .bubble_ex1(bubble_ex1),
    .fwd_sel_a(fwd_sel_a), .fwd_sel_b(fwd_sel_b)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic put(input int i, input logic [1:0] k, input logic [4:0] rd,
                     input logic [4:0] r1, input logic [4:0] r2,
                     input logic [1:0] ea, input logic [1:0] eb);
    p_kind[i] = k; p_rd[i] = rd; p_rs1[i] = r1; p_rs2[i] = r2; e_a[i] = ea; e_b[i] = eb;
  endtask

  task automatic run_prog(input string req, input logic [1:0] mode, input int n, input int exp_stalls);
    int pc = 0, last = -1, stalls = 0, cyc = 0;
    logic was_stall = 1'b0;
    cfg_mode = mode;
    while (pc < n || last >= 0) begin
      @(negedge clk);
      if (last >= 0) begin
        check(req, $sformatf("sel_a of instr %0d", last), int'(fwd_sel_a), int'(e_a[last]));
        check(req, $sformatf("sel_b of instr %0d", last), int'(fwd_sel_b), int'(e_b[last]));
        last = -1;
      end else if (was_stall) begin
        check("R8", "bubble sels zero", int'({fwd_sel_a, fwd_sel_b}), 0);
      end
      was_stall = 1'b0;
      if (pc < n) begin
        id_valid = 1'b1; id_kind = p_kind[pc]; id_rd = p_rd[pc];
        id_rs1 = p_rs1[pc]; id_rs2 = p_rs2[pc];
      end else begin
        id_valid = 1'b0;
      end
      #1;
      if (pc < n) begin
        cyc++;
        if (stall_id) begin
          stalls++;
          was_stall = 1'b1;
          if (!(stall_if && bubble_ex1)) check("R8", "stall lines agree", 0, 1);
        end else begin
          last = pc;
          pc++;
        end
      end
    end
    id_valid = 1'b0;
    check(req, "stall cycles", stalls, exp_stalls);
    check(req, "total cycles", cyc + 5, n + 5 + exp_stalls);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      if (stall_if) check("R10", "idle stall", 1, 0);
    end
    check("R10", "idle no stall", int'(stall_if), 0);
  endtask

  // add x3,x26,x19 ; mul x12,x28,x3 ; sub x19,x28,x12 ; or x25,x12,x19
  task automatic t_alu_mul(input logic [1:0] mode);
    case (mode)
      2'd0: begin
        put(0, ALU, 3, 26, 19, 0, 0); put(1, MUL, 12, 28, 3, 0, 1);
        put(2, ALU, 19, 28, 12, 0, 2); put(3, ALU, 25, 12, 19, 3, 1);
        run_prog("R1 R2", mode, 4, 1);
      end
      2'd1: begin
        put(0, ALU, 3, 26, 19, 0, 0); put(1, MUL, 12, 28, 3, 0, 0);
        put(2, ALU, 19, 28, 12, 0, 0); put(3, ALU, 25, 12, 19, 0, 0);
        run_prog("R4", mode, 4, 9);
      end
      default: begin
        put(0, ALU, 3, 26, 19, 0, 0); put(1, MUL, 12, 28, 3, 0, 3);
        put(2, ALU, 19, 28, 12, 0, 3); put(3, ALU, 25, 12, 19, 0, 3);
        run_prog("R5", mode, 4, 6);
      end
    endcase
  endtask

  // lw x2,(x14) ; add x10,x0,x2 ; lw x14,(x10) ; sub x22,x10,x30
  task automatic t_load(input logic [1:0] mode);
    case (mode)
      2'd0: begin
        put(0, LD, 2, 14, 0, 0, 0); put(1, ALU, 10, 0, 2, 0, 3);
        put(2, LD, 14, 10, 0, 1, 0); put(3, ALU, 22, 10, 30, 2, 0);
        run_prog("R3", mode, 4, 2);
      end
      2'd1: begin
        put(0, LD, 2, 14, 0, 0, 0); put(1, ALU, 10, 0, 2, 0, 0);
        put(2, LD, 14, 10, 0, 0, 0); put(3, ALU, 22, 10, 30, 0, 0);
        run_prog("R4", mode, 4, 6);
      end
      default: begin
        put(0, LD, 2, 14, 0, 0, 0); put(1, ALU, 10, 0, 2, 0, 3);
        put(2, LD, 14, 10, 0, 3, 0); put(3, ALU, 22, 10, 30, 0, 0);
        run_prog("R5", mode, 4, 5);
      end
    endcase
  endtask

  // add x0,x1,x2 ; sub x27,x10,x0 ; and x12,x0,x27
  task automatic t_zero_reg();
    put(0, ALU, 0, 1, 2, 0, 0); put(1, ALU, 27, 10, 0, 0, 0); put(2, ALU, 12, 0, 27, 0, 1);
    run_prog("R6", 2'd0, 3, 0);
    put(2, ALU, 12, 0, 27, 0, 0);
    run_prog("R6", 2'd1, 3, 3);
  endtask

  task automatic t_youngest();
    // older mul, younger add to x5: add wins, no stall
    put(0, MUL, 5, 1, 2, 0, 0); put(1, ALU, 5, 3, 4, 0, 0); put(2, ALU, 7, 5, 5, 1, 1);
    run_prog("R7", 2'd0, 3, 0);
    // older add, younger mul to x5: mul wins, one stall
    put(0, ALU, 5, 1, 2, 0, 0); put(1, MUL, 5, 3, 4, 0, 0); put(2, ALU, 7, 5, 0, 2, 0);
    run_prog("R7", 2'd0, 3, 1);
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    check("R9", "stall after reset", int'({stall_if, stall_id, bubble_ex1}), 0);
    check("R9", "sels after reset", int'({fwd_sel_a, fwd_sel_b}), 0);
  endtask

  task automatic t_reserved_mode();
    put(0, ALU, 3, 1, 2, 0, 0); put(1, ALU, 4, 3, 0, 0, 0);
    run_prog("R4", 2'd3, 2, 3);
  endtask

  initial begin
    rst_n = 1'b0; cfg_mode = 2'd0; id_valid = 1'b0; id_kind = 2'd0;
    id_rd = '0; id_rs1 = '0; id_rs2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    for (int m = 0; m < 3; m++) t_alu_mul(2'(m));
    for (int m = 0; m < 3; m++) t_load(2'(m));
    t_zero_reg();
    t_youngest();
    t_reserved_mode();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule